// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a phase-locked loop has settled. It watches the reference and feedback edge pulses that reach the phase-frequency detector, both already synchronised to a fast sampling clock. On every comparison cycle it counts how many sampling periods separate the earlier edge from the later one. It reports that count with a one-cycle strobe, then drives a single lock flag from the result.

The flag rises only after a programmable run of consecutive comparisons whose error sits inside a narrow lock window. Once the flag is high, only one comparison beyond a wider loss-of-lock threshold clears it. Errors between the two limits leave the locked state alone, so the flag does not chatter near the edge of the window.

If the trailing edge is late enough that the count has already passed the loss-of-lock threshold, the comparison is scored at once as out of threshold. The block does not wait for that edge. All limits are runtime inputs in sampling-clock periods. The loss-of-lock threshold must be larger than the lock window and below the largest count the error field can hold.

Top module: `pll_lock_detect`

## Requirements
- R1: In the cycle after reset is released, `locked` and `meas_valid` are both 0. `locked` is 1 only while the loop is judged locked.
- R2: When one input pulses and the other input pulses d sampling cycles later (either input may lead), `meas_valid` is 1 for one cycle with `meas_err` = d. The strobe is visible right after the edge that samples the trailing pulse.
- R3: Pulses on both inputs in the same cycle, with no comparison open, give a strobe with `meas_err` = 0. That comparison counts as in window.
- R4: A result is in window when `meas_err` <= `lock_win`. While unlocked, `locked` rises one cycle after the strobe of the `lock_cnt`-th consecutive in-window result.
- R5: While unlocked, a result that is not in window restarts the run. A full `lock_cnt` of fresh in-window results is then needed.
- R6: A `lock_cnt` of 0 or 1 locks on the first in-window result.
- R7: While locked, a result with `meas_err` > `unlock_thr` clears `locked` one cycle after its strobe.
- R8: While locked, results with `lock_win` < `meas_err` <= `unlock_thr` leave `locked` at 1.
- R9: If the trailing pulse has not arrived when the count reaches `unlock_thr`+1, a strobe appears at that point with `meas_err` = `unlock_thr`+1. This is `unlock_thr`+1 cycles after the edge that sampled the leading pulse.
- R10: While a comparison is open, further pulses on the leading input are ignored. The error is still measured from the first leading pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_pulse | input | 1 | One-cycle pulse per reference edge |
| fb_pulse | input | 1 | One-cycle pulse per feedback edge |
| lock_win | input | ERR_W | Lock window in sampling periods |
| unlock_thr | input | ERR_W | Loss-of-lock threshold in sampling periods |
| lock_cnt | input | CNT_W | Consecutive in-window results needed to lock |
| locked | output | 1 | Lock flag |
| meas_valid | output | 1 | One-cycle strobe per finished comparison |
| meas_err | output | ERR_W | Measured phase error in sampling periods |

## Verification
Each comparison result is due on the clock edge that samples the trailing pulse. A timed-out result is due `unlock_thr`+1 edges after the leading pulse is sampled. The lock flag follows one edge after the strobe. The bench drives pulses on falling edges and counts falling edges from the leading pulse. It reads `meas_valid` and `meas_err` one falling edge after the trailing pulse, and reads `locked` one falling edge later. It also checks that the strobe is absent on the falling edges just before and just after its due point.

// File: rtl/pll_ld_pkg.sv
`timescale 1ns/1ps
package pll_ld_pkg;

  typedef enum logic {
    MS_IDLE = 1'b0,
    MS_OPEN = 1'b1
  } meas_state_e;

  // error within the narrow window
  function automatic logic err_in_window(input logic [31:0] err, input logic [31:0] win);
    return err <= win;
  endfunction

  // error past the wide threshold
  function automatic logic err_past_limit(input logic [31:0] err, input logic [31:0] thr);
    return err > thr;
  endfunction

  // run length that declares lock; zero behaves as one
  function automatic logic [31:0] run_goal(input logic [31:0] req);
    return (req == 0) ? 32'd1 : req;
  endfunction

endpackage

// File: rtl/pll_phase_meter.sv
`timescale 1ns/1ps
module pll_phase_meter
  import pll_ld_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_pulse,
  input  logic             fb_pulse,
  input  logic [ERR_W-1:0] unlock_thr,
  output logic             meas_valid,
  output logic [ERR_W-1:0] meas_err
);

  localparam logic [ERR_W-1:0] CNT_MAX = {ERR_W{1'b1}};

  meas_state_e      state_q;
  logic             lead_ref_q;
  logic [ERR_W-1:0] span_q;

  // named events for checking
  logic             both_now;
  logic             trail_hit;
  logic             timed_out;
  logic             done;
  logic [ERR_W-1:0] err_n;

  assign both_now  = (state_q == MS_IDLE) && ref_pulse && fb_pulse;
  assign trail_hit = (state_q == MS_OPEN) && (lead_ref_q ? fb_pulse : ref_pulse);
  assign timed_out = (state_q == MS_OPEN) && !trail_hit &&
                     err_past_limit(32'(span_q), 32'(unlock_thr));
  assign done      = both_now || trail_hit || timed_out;

  always_comb begin
    err_n = '0;
    if (trail_hit || timed_out) err_n = span_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= MS_IDLE;
      lead_ref_q <= 1'b0;
      span_q     <= '0;
      meas_valid <= 1'b0;
      meas_err   <= '0;
    end else begin
      meas_valid <= done;
      if (done) meas_err <= err_n;
      unique case (state_q)
        MS_IDLE: begin
          if (ref_pulse ^ fb_pulse) begin
            state_q    <= MS_OPEN;
            lead_ref_q <= ref_pulse;
            span_q     <= {{(ERR_W-1){1'b0}}, 1'b1};
          end
        end
        MS_OPEN: begin
          if (done) begin
            state_q <= MS_IDLE;
            span_q  <= '0;
          end else if (span_q != CNT_MAX) begin
            span_q <= span_q + 1'b1;
          end
        end
        default: state_q <= MS_IDLE;
      endcase
    end
  end

  // R3
  zero_err_chk: assert property (@(posedge clk) disable iff (rst)
    both_now |=> (meas_valid && meas_err == '0));

  // R9
  timeout_err_chk: assert property (@(posedge clk) disable iff (rst)
    timed_out |=> (meas_valid && meas_err == ERR_W'($past(unlock_thr) + 1'b1)));

  // R10
  lead_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == MS_OPEN && !done) |=> (state_q == MS_OPEN || $past(span_q) == CNT_MAX
                                       || span_q == $past(span_q) + 1'b1));

  // R2
  strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
    meas_valid |-> $past(state_q == MS_OPEN || (ref_pulse && fb_pulse)));

endmodule

// File: rtl/pll_window_judge.sv
`timescale 1ns/1ps
module pll_window_judge
  import pll_ld_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic [ERR_W-1:0] meas_err,
  input  logic [ERR_W-1:0] lock_win,
  input  logic [ERR_W-1:0] unlock_thr,
  output logic             in_win,
  output logic             past_thr
);

  assign in_win   = err_in_window(32'(meas_err), 32'(lock_win));
  assign past_thr = err_past_limit(32'(meas_err), 32'(unlock_thr));

endmodule

// File: rtl/pll_lock_fsm.sv
`timescale 1ns/1ps
module pll_lock_fsm
  import pll_ld_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             meas_valid,
  input  logic             in_win,
  input  logic             past_thr,
  input  logic [CNT_W-1:0] lock_cnt,
  output logic             locked
);

  logic [CNT_W:0] run_q;
  logic [CNT_W:0] run_next;
  logic [CNT_W:0] goal;
  logic           good_res;
  logic           bad_res;
  logic           drop_res;

  assign goal     = (CNT_W+1)'(run_goal(32'(lock_cnt)));
  assign run_next = run_q + 1'b1;
  assign good_res = !locked && meas_valid && in_win;
  assign bad_res  = !locked && meas_valid && !in_win;
  assign drop_res = locked && meas_valid && past_thr;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      run_q  <= '0;
    end else if (good_res) begin
      if (run_next >= goal) begin
        locked <= 1'b1;
        run_q  <= '0;
      end else begin
        run_q <= run_next;
      end
    end else if (bad_res) begin
      run_q <= '0;
    end else if (drop_res) begin
      locked <= 1'b0;
      run_q  <= '0;
    end
  end

  // R4
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(meas_valid && in_win));

  // R7
  fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(meas_valid && past_thr));

  // R8
  hold_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && !(meas_valid && past_thr)) |=> locked);

  // R5
  run_clear_chk: assert property (@(posedge clk) disable iff (rst)
    bad_res |=> (run_q == '0 && !locked));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !locked);

endmodule

// File: rtl/pll_lock_detect.sv
`timescale 1ns/1ps
module pll_lock_detect #(
  parameter int ERR_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_pulse,
  input  logic             fb_pulse,
  input  logic [ERR_W-1:0] lock_win,
  input  logic [ERR_W-1:0] unlock_thr,
  input  logic [CNT_W-1:0] lock_cnt,
  output logic             locked,
  output logic             meas_valid,
  output logic [ERR_W-1:0] meas_err
);

  logic in_win;
  logic past_thr;

  pll_phase_meter #(.ERR_W(ERR_W)) u_meter (
    .clk        (clk),
    .rst        (rst),
    .ref_pulse  (ref_pulse),
    .fb_pulse   (fb_pulse),
    .unlock_thr (unlock_thr),
    .meas_valid (meas_valid),
    .meas_err   (meas_err)
  );

  pll_window_judge #(.ERR_W(ERR_W)) u_judge (
    .meas_err   (meas_err),
    .lock_win   (lock_win),
    .unlock_thr (unlock_thr),
    .in_win     (in_win),
    .past_thr   (past_thr)
  );

  pll_lock_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .meas_valid (meas_valid),
    .in_win     (in_win),
    .past_thr   (past_thr),
    .lock_cnt   (lock_cnt),
    .locked     (locked)
  );

  // R2
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (meas_valid && !$past(ref_pulse || fb_pulse)) |=> !meas_valid);

endmodule

// File: tb/pll_lock_detect_bench.sv
`timescale 1ns/1ps
module pll_lock_detect_bench;

  localparam int ERR_W = 8;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ref_p = 1'b0;
  logic             fb_p = 1'b0;
  logic [ERR_W-1:0] lock_win = 8'd3;
  logic [ERR_W-1:0] unlock_thr = 8'd8;
  logic [CNT_W-1:0] lock_cnt = 4'd5;
  logic             locked;
  logic             meas_valid;
  logic [ERR_W-1:0] meas_err;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  pll_lock_detect #(.ERR_W(ERR_W), .CNT_W(CNT_W)) u_pll_lock_detect (
    .clk(clk), .rst(rst), .ref_pulse(ref_p), .fb_pulse(fb_p),
    .lock_win(lock_win), .unlock_thr(unlock_thr), .lock_cnt(lock_cnt),
    .locked(locked), .meas_valid(meas_valid), .meas_err(meas_err)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // pulse pair; lead_ref picks the leading input, d the gap in cycles
  task automatic pair(input bit lead_ref, input int d, input int exp_err,
                      input string req, output bit lk);
    @(negedge clk);
    if (d == 0) begin ref_p = 1; fb_p = 1; end
    else if (lead_ref) ref_p = 1;
    else fb_p = 1;
    for (int i = 1; i <= d; i++) begin
      @(negedge clk);
      ref_p = 0; fb_p = 0;
      if (i == d) begin
        if (lead_ref) fb_p = 1; else ref_p = 1;
      end else begin
        check({req, " no early strobe"}, meas_valid, 0);
      end
    end
    @(negedge clk);
    ref_p = 0; fb_p = 0;
    check({req, " strobe"}, meas_valid, 1);
    check({req, " err"}, meas_err, exp_err);
    @(negedge clk);
    check({req, " single strobe"}, meas_valid, 0);
    lk = locked;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 locked after reset", locked, 0);
    check("R1 strobe after reset", meas_valid, 0);
  endtask

  task automatic t_measure();
    bit lk;
    lock_cnt = 4'd15;
    pair(1, 2, 2, "R2 ref leads", lk);
    pair(0, 5, 5, "R2 fb leads", lk);
    pair(1, 0, 0, "R3 same cycle", lk);
    pair(0, 7, 7, "R2 fb leads 7", lk);
  endtask

  task automatic t_qualify();
    bit lk;
    do_reset();
    lock_cnt = 4'd5;
    for (int i = 0; i < 4; i++) pair(i[0], 2, 2, "R4 run", lk);
    check("R4 not yet locked", lk, 0);
    pair(1, 5, 5, "R5 break", lk);
    check("R5 break unlocked", lk, 0);
    for (int i = 0; i < 4; i++) pair(1, 3, 3, "R5 rerun", lk);
    check("R5 run restarted", lk, 0);
    pair(0, 0, 0, "R4 fifth", lk);
    check("R4 locked after five", lk, 1);
  endtask

  task automatic t_hysteresis();
    bit lk;
    pair(1, 6, 6, "R8 mid", lk);
    check("R8 hold at 6", lk, 1);
    pair(0, 8, 8, "R8 at threshold", lk);
    check("R8 hold at 8", lk, 1);
  endtask

  task automatic t_timeout();
    int thr = int'(unlock_thr);
    @(negedge clk);
    ref_p = 1;
    for (int i = 1; i <= thr + 1; i++) begin
      @(negedge clk);
      ref_p = 0;
      check("R9 no early strobe", meas_valid, 0);
    end
    @(negedge clk);
    check("R9 timeout strobe", meas_valid, 1);
    check("R9 timeout err", meas_err, thr + 1);
    @(negedge clk);
    check("R7 unlocked after timeout", locked, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_single();
    bit lk;
    do_reset();
    lock_cnt = 4'd1;
    pair(1, 4, 4, "R4 just outside", lk);
    check("R4 err 4 not in window", lk, 0);
    pair(1, 3, 3, "R6 edge of window", lk);
    check("R6 lock on first", lk, 1);
    pair(0, 9, 9, "R7 past threshold", lk);
    check("R7 drop", lk, 0);
    lock_cnt = 4'd0;
    pair(1, 1, 1, "R6 zero count", lk);
    check("R6 zero count locks", lk, 1);
  endtask

  task automatic t_repeat_lead();
    do_reset();
    @(negedge clk); ref_p = 1;
    @(negedge clk); ref_p = 0;
    @(negedge clk); ref_p = 1;
    @(negedge clk); ref_p = 0;
    @(negedge clk); fb_p = 1;
    @(negedge clk); fb_p = 0;
    check("R10 strobe", meas_valid, 1);
    check("R10 err from first lead", meas_err, 4);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_measure();
    t_qualify();
    t_hysteresis();
    t_timeout();
    t_single();
    t_repeat_lead();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule